// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block manages, on the device side, one receive ring of buffer descriptors that live in host memory. Software tells the block how far it has prepared the ring by writing a producer (write) index. The receive path reports frame starts and frame ends. Each time a buffer is closed, the block advances its read index and asks for a status write-back that carries the updated index. It can also raise an interrupt toward the host. Descriptor fetching and frame data movement happen outside the block. Only the index bookkeeping, the enable modes and the close timer are modelled here.

The ring holds a power-of-two number of descriptors, chosen by an exponent. A buffer closes either when a frame ends with a "buffer full" mark, or when a partly filled buffer has waited a programmable number of timeout units with no frame in progress. The enable field has three modes: run, stop at the end of the current frame, and stop at once. The enable field also drives an idle indication.

Top module: `rxring_ctrl`

## Requirements
- R1: After reset, rd_idx, free_cnt, stat_wr and irq are 0, buf_avail is 0 and idle is 1. The configuration resets to stopped, exponent 8, no interrupt and timeout 16.
- R2: The ring holds 2^E entries. E is cfg_exp clamped to the range 5..IDX_W. Values below 5 act as 5 and values above IDX_W act as IDX_W. Both indices are reduced modulo the ring size, so rd_idx wraps from 2^E-1 to 0.
- R3: A write-index update stores widx_val rounded down to a multiple of 8. The stored value is then reduced modulo the ring size, and free_cnt equals (write index - rd_idx) mod 2^E.
- R4: buf_avail is 1 exactly when rd_idx differs from the write index. A frame start while buf_avail is 0 is ignored: it closes no buffer and leaves rd_idx unchanged.
- R5: In run mode (cfg_en = 2'b10), a started frame whose frm_end carries frm_fill closes the buffer. On the clock edge that samples frm_end, rd_idx advances by 1 and stat_wr pulses for one cycle with stat_idx equal to the new rd_idx.
- R6: In stop-at-frame-end mode (cfg_en = 2'b01), a frame already in progress completes and closes normally. New frame starts are ignored.
- R7: In stop mode (cfg_en = 2'b00, and also 2'b11), a frame in progress is dropped one cycle after the mode takes effect. Its later frm_end closes nothing.
- R8: A frame end without frm_fill leaves a partly filled buffer. If no frame starts afterwards, that buffer closes exactly T x TICK_CYCLES cycles after the edge that sampled frm_end, where T is cfg_tmo. T = 0 disables the timer, and the buffer then closes only on a later filled frame end.
- R9: irq pulses together with stat_wr on every buffer close only when cfg_irq_dst = 2'b01. Any other destination value gives no irq.
- R10: idle is 1 exactly when the enable mode is not run (2'b10) and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads all configuration fields |
| cfg_en | input | 2 | Enable mode: 00 stop, 01 stop at frame end, 10 run |
| cfg_exp | input | 4 | Ring size exponent |
| cfg_irq_dst | input | 2 | Interrupt destination: 01 host, others none |
| cfg_tmo | input | TMO_W | Close timeout in units of TICK_CYCLES |
| widx_wr | input | 1 | Loads the write index |
| widx_val | input | IDX_W | New write index |
| frm_start | input | 1 | Receive path begins a frame |
| frm_end | input | 1 | Receive path finishes the current frame |
| frm_fill | input | 1 | With frm_end: the buffer is now full |
| buf_avail | output | 1 | A free descriptor is ready to fill |
| free_cnt | output | IDX_W | Descriptors ready to fill |
| rd_idx | output | IDX_W | Next descriptor to fill |
| stat_wr | output | 1 | Status write-back request |
| stat_idx | output | IDX_W | Index carried by the status write-back |
| irq | output | 1 | Host interrupt pulse |
| idle | output | 1 | Channel disabled with no frame in progress |

## Verification
The bench builds the block with IDX_W = 12 and TICK_CYCLES = 4, so one timeout unit lasts four clocks. A timeout of 3 units then closes a buffer 12 cycles after its frame end, which makes it possible to count the exact close cycle. Keeping the full 12-bit index allows exponents 5 and 12 to be reached. The 32-entry ring wraps after a few dozen frames. Clamping of both out-of-range exponents, and masking of a write index larger than the ring, are therefore observable in one short run.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    EN_STOP = 2'b00,
    EN_EOF  = 2'b01,
    EN_RUN  = 2'b10,
    EN_RSVD = 2'b11
  } en_mode_e;

  // Mask that reduces an index modulo 2^e.
  function automatic int unsigned ring_mask(input logic [3:0] e);
    return (32'd1 << e) - 32'd1;
  endfunction

  function automatic logic [3:0] clamp_exp(input logic [3:0] e,
                                           input logic [3:0] lo,
                                           input logic [3:0] hi);
    if (e < lo) return lo;
    if (e > hi) return hi;
    return e;
  endfunction

  // Producer index moves in steps of eight descriptors.
  function automatic int unsigned round8(input int unsigned v);
    return v & ~32'd7;
  endfunction

  function automatic int unsigned next_idx(input int unsigned i,
                                           input int unsigned m);
    return (i + 32'd1) & m;
  endfunction

  function automatic int unsigned ring_dist(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned m);
    return (a - b) & m;
  endfunction

  function automatic logic halted(input en_mode_e e);
    return (e == EN_STOP) || (e == EN_RSVD);
  endfunction

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg
  import rxr_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int TMO_W   = 8,
  parameter int MIN_EXP = 5,
  parameter int DEF_EXP = 8,
  parameter int DEF_TMO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_en,
  input  logic [3:0]       cfg_exp,
  input  logic [1:0]       cfg_irq_dst,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             widx_wr,
  input  logic [IDX_W-1:0] widx_val,
  output en_mode_e         en_q,
  output logic             irq_host,
  output logic [TMO_W-1:0] tmo_q,
  output logic [IDX_W-1:0] mask,
  output logic [IDX_W-1:0] wr_idx
);

  localparam logic [3:0] EXP_LO = 4'(MIN_EXP);
  localparam logic [3:0] EXP_HI = 4'(IDX_W);

  logic [3:0]       exp_q;
  logic [IDX_W-1:0] wr_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= EN_STOP;
      exp_q    <= 4'(DEF_EXP);
      irq_host <= 1'b0;
      tmo_q    <= TMO_W'(DEF_TMO);
    end else if (cfg_wr) begin
      en_q     <= en_mode_e'(cfg_en);
      exp_q    <= clamp_exp(cfg_exp, EXP_LO, EXP_HI);
      irq_host <= (cfg_irq_dst == 2'b01);
      tmo_q    <= cfg_tmo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wr_raw <= '0;
    else if (widx_wr) wr_raw <= IDX_W'(round8(32'(widx_val)));
  end

  assign mask   = IDX_W'(ring_mask(exp_q));
  assign wr_idx = wr_raw & mask;

endmodule

// File: rtl/rxr_timer.sv
module rxr_timer #(
  parameter int TICK_CYCLES = 1600,
  parameter int TMO_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] tmo,
  output logic             expire
);

  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] units_q;
  logic             tick;

  assign tick   = run && (pre_q == PRE_LAST);
  assign expire = tick && (tmo != '0) && (units_q == tmo - TMO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (tick) begin
      pre_q   <= '0;
      units_q <= units_q + TMO_W'(1);
    end else begin
      pre_q   <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
  import rxr_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  en_mode_e         en,
  input  logic [IDX_W-1:0] mask,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             frm_fill,
  input  logic             tmo_close,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] rd_next,
  output logic [IDX_W-1:0] free_cnt,
  output logic             buf_avail,
  output logic             in_frame,
  output logic             part,
  output logic             start_ok,
  output logic             close
);

  logic [IDX_W-1:0] rd_q;
  logic             end_ok;

  assign rd_idx    = rd_q & mask;
  assign rd_next   = IDX_W'(next_idx(32'(rd_idx), 32'(mask)));
  assign buf_avail = (rd_idx != wr_idx);
  assign free_cnt  = IDX_W'(ring_dist(32'(wr_idx), 32'(rd_idx), 32'(mask)));

  assign start_ok = frm_start && !in_frame && (en == EN_RUN) && buf_avail && !tmo_close;
  assign end_ok   = frm_end && in_frame && !halted(en);
  assign close    = (end_ok && frm_fill) || (tmo_close && part);

  always_ff @(posedge clk) begin
    if (!rst_n)           in_frame <= 1'b0;
    else if (halted(en))  in_frame <= 1'b0;
    else if (start_ok)    in_frame <= 1'b1;
    else if (end_ok)      in_frame <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     part <= 1'b0;
    else if (end_ok && !frm_fill)   part <= 1'b1;
    else if (close)                 part <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (close) rd_q <= rd_next;
  end

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxr_pkg::*;
#(
  parameter int IDX_W       = 12,
  parameter int TMO_W       = 8,
  parameter int MIN_EXP     = 5,
  parameter int TICK_CYCLES = 1600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_en,
  input  logic [3:0]       cfg_exp,
  input  logic [1:0]       cfg_irq_dst,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             widx_wr,
  input  logic [IDX_W-1:0] widx_val,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             frm_fill,
  output logic             buf_avail,
  output logic [IDX_W-1:0] free_cnt,
  output logic [IDX_W-1:0] rd_idx,
  output logic             stat_wr,
  output logic [IDX_W-1:0] stat_idx,
  output logic             irq,
  output logic             idle
);

  en_mode_e         en_q;
  logic             irq_host;
  logic [TMO_W-1:0] tmo_q;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_next;
  logic             in_frame;
  logic             part;
  logic             start_ok;
  logic             close;
  logic             tmo_close;
  logic             tmr_run;

  rxr_cfg #(
    .IDX_W   (IDX_W),
    .TMO_W   (TMO_W),
    .MIN_EXP (MIN_EXP)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_en      (cfg_en),
    .cfg_exp     (cfg_exp),
    .cfg_irq_dst (cfg_irq_dst),
    .cfg_tmo     (cfg_tmo),
    .widx_wr     (widx_wr),
    .widx_val    (widx_val),
    .en_q        (en_q),
    .irq_host    (irq_host),
    .tmo_q       (tmo_q),
    .mask        (mask),
    .wr_idx      (wr_idx)
  );

  assign tmr_run = part && !in_frame;

  rxr_timer #(
    .TICK_CYCLES (TICK_CYCLES),
    .TMO_W       (TMO_W)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .tmo    (tmo_q),
    .expire (tmo_close)
  );

  rxr_fill #(
    .IDX_W (IDX_W)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .mask      (mask),
    .wr_idx    (wr_idx),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .frm_fill  (frm_fill),
    .tmo_close (tmo_close),
    .rd_idx    (rd_idx),
    .rd_next   (rd_next),
    .free_cnt  (free_cnt),
    .buf_avail (buf_avail),
    .in_frame  (in_frame),
    .part      (part),
    .start_ok  (start_ok),
    .close     (close)
  );

  // Status write-back and interrupt stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_wr  <= 1'b0;
      irq      <= 1'b0;
      stat_idx <= '0;
    end else begin
      stat_wr <= close;
      irq     <= close && irq_host;
      if (close) stat_idx <= rd_next;
    end
  end

  assign idle = (en_q != EN_RUN) && !in_frame;

endmodule

// File: rtl/rxring_ctrl_chk.sv
module rxring_ctrl_chk
  import rxr_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input en_mode_e         en_q,
  input logic             cfg_wr,
  input logic             irq_host,
  input logic             in_frame,
  input logic             part,
  input logic             buf_avail,
  input logic             tmo_close,
  input logic [IDX_W-1:0] mask,
  input logic [IDX_W-1:0] rd_idx,
  input logic             stat_wr,
  input logic [IDX_W-1:0] stat_idx,
  input logic             irq,
  input logic             idle
);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !$past(cfg_wr) && ($past(rd_idx) == mask)) |-> (rd_idx == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(buf_avail));

  assert_move_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_idx != $past(rd_idx)) && !$past(cfg_wr)) |-> stat_wr);

  assert_stat_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !$past(cfg_wr)) |-> (stat_idx == rd_idx));

  assert_eof_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q == EN_EOF) && !in_frame) |=> !in_frame);

  assert_stop_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == EN_STOP) |=> !in_frame);

  assert_tmo_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_close |-> (part && !in_frame));

  assert_irq_with_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_wr && $past(irq_host)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !$rose(in_frame));

endmodule

bind rxring_ctrl rxring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .cfg_wr    (cfg_wr),
  .irq_host  (irq_host),
  .in_frame  (in_frame),
  .part      (part),
  .buf_avail (buf_avail),
  .tmo_close (tmo_close),
  .mask      (mask),
  .rd_idx    (rd_idx),
  .stat_wr   (stat_wr),
  .stat_idx  (stat_idx),
  .irq       (irq),
  .idle      (idle)
);

// File: tb/rxring_ctrl_tb.sv
module rxring_ctrl_tb;

  localparam int IDX_W = 12;
  localparam int TMO_W = 8;
  localparam int TICK  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [1:0]       cfg_en = 2'b00;
  logic [3:0]       cfg_exp = 4'd8;
  logic [1:0]       cfg_irq_dst = 2'b00;
  logic [TMO_W-1:0] cfg_tmo = '0;
  logic             widx_wr = 1'b0;
  logic [IDX_W-1:0] widx_val = '0;
  logic             frm_start = 1'b0;
  logic             frm_end = 1'b0;
  logic             frm_fill = 1'b0;
  logic             buf_avail;
  logic [IDX_W-1:0] free_cnt;
  logic [IDX_W-1:0] rd_idx;
  logic             stat_wr;
  logic [IDX_W-1:0] stat_idx;
  logic             irq;
  logic             idle;

  int n_chk  = 0;
  int n_fail = 0;
  int m_rd   = 0;
  int m_wraw = 0;
  int m_size = 256;
  bit m_host = 0;

  always #10 clk = ~clk;

  rxring_ctrl #(
    .IDX_W       (IDX_W),
    .TMO_W       (TMO_W),
    .MIN_EXP     (5),
    .TICK_CYCLES (TICK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_exp(cfg_exp),
    .cfg_irq_dst(cfg_irq_dst), .cfg_tmo(cfg_tmo), .widx_wr(widx_wr), .widx_val(widx_val),
    .frm_start(frm_start), .frm_end(frm_end), .frm_fill(frm_fill), .buf_avail(buf_avail),
    .free_cnt(free_cnt), .rd_idx(rd_idx), .stat_wr(stat_wr), .stat_idx(stat_idx),
    .irq(irq), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_free();
    return ((m_wraw % m_size) - m_rd + m_size) % m_size;
  endfunction

  task automatic do_cfg(input logic [1:0] en, input logic [3:0] e,
                        input logic [1:0] dst, input logic [7:0] t);
    int eff;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_en = en; cfg_exp = e; cfg_irq_dst = dst; cfg_tmo = t;
    @(negedge clk);
    cfg_wr = 1'b0;
    eff = (e < 5) ? 5 : ((e > 12) ? 12 : int'(e));
    m_size = 1 << eff;
    m_rd   = m_rd % m_size;
    m_host = (dst == 2'b01);
  endtask

  task automatic do_widx(input int v);
    @(negedge clk);
    widx_wr = 1'b1; widx_val = IDX_W'(v);
    @(negedge clk);
    widx_wr = 1'b0;
    m_wraw = v - (v % 8);
  endtask

  task automatic frm_begin();
    @(negedge clk);
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  task automatic frm_finish(input bit fill, output bit s, output bit q,
                            output int idx);
    @(negedge clk);
    frm_end = 1'b1; frm_fill = fill;
    @(negedge clk);
    frm_end = 1'b0; frm_fill = 1'b0;
    s = stat_wr; q = irq; idx = int'(stat_idx);
  endtask

  task automatic run_frame(input bit fill, output bit s, output bit q,
                           output int idx);
    frm_begin();
    frm_finish(fill, s, q, idx);
  endtask

  task automatic t_reset();
    chk(rd_idx == 0, "R1", "rd_idx", rd_idx, 0);
    chk(free_cnt == 0 && !buf_avail, "R1", "free_cnt", free_cnt, 0);
    chk(!stat_wr && !irq, "R1", "stat_wr/irq", {stat_wr, irq}, 0);
    chk(idle, "R1", "idle", idle, 1);
  endtask

  task automatic t_fill_basic();
    bit s, q; int idx;
    do_cfg(2'b10, 4'd8, 2'b01, 8'd0);
    do_widx(13);
    chk(free_cnt == 8, "R3", "free after odd write", free_cnt, 8);
    chk(!idle, "R10", "idle in run", idle, 0);
    for (int i = 0; i < 8; i++) begin
      run_frame(1'b1, s, q, idx);
      m_rd = (m_rd + 1) % m_size;
      chk(s, "R5", "stat_wr on close", s, 1);
      chk(idx == m_rd, "R5", "stat_idx", idx, m_rd);
      chk(rd_idx == m_rd, "R5", "rd_idx", rd_idx, m_rd);
      chk(q, "R9", "irq to host", q, 1);
    end
    chk(!buf_avail && free_cnt == 0, "R4", "ring full", buf_avail, 0);
    run_frame(1'b1, s, q, idx);
    chk(!s, "R4", "start ignored when full", s, 0);
    chk(rd_idx == m_rd, "R4", "rd_idx kept", rd_idx, m_rd);
  endtask

  task automatic t_wrap();
    bit s, q; int idx; int n;
    do_cfg(2'b10, 4'd3, 2'b01, 8'd0);
    do_widx(4);
    chk(free_cnt == exp_free(), "R2", "free with clamped exp 5", free_cnt, exp_free());
    n = exp_free();
    for (int i = 0; i < n; i++) begin
      run_frame(1'b1, s, q, idx);
      m_rd = (m_rd + 1) % m_size;
      chk(s && idx == m_rd, "R2", "stat_idx across wrap", idx, m_rd);
    end
    chk(rd_idx == 0, "R2", "rd_idx wrapped to 0", rd_idx, 0);
    do_widx(45);
    chk(free_cnt == 8, "R2", "write index masked to ring", free_cnt, 8);
    do_cfg(2'b10, 4'd15, 2'b01, 8'd0);
    chk(free_cnt == 40, "R2", "exp clamped to 12", free_cnt, 40);
  endtask

  task automatic t_eof();
    bit s, q; int idx;
    do_cfg(2'b10, 4'd8, 2'b01, 8'd0);
    frm_begin();
    do_cfg(2'b01, 4'd8, 2'b01, 8'd0);
    chk(!idle, "R10", "not idle mid frame", idle, 0);
    frm_finish(1'b1, s, q, idx);
    m_rd = (m_rd + 1) % m_size;
    chk(s && idx == m_rd, "R6", "frame in progress completes", idx, m_rd);
    chk(idle, "R10", "idle after frame end", idle, 1);
    run_frame(1'b1, s, q, idx);
    chk(!s && rd_idx == m_rd, "R6", "new start ignored", s, 0);
  endtask

  task automatic t_stop();
    bit s, q; int idx;
    do_cfg(2'b10, 4'd8, 2'b01, 8'd0);
    frm_begin();
    do_cfg(2'b00, 4'd8, 2'b01, 8'd0);
    @(negedge clk);
    chk(idle, "R7", "idle after stop", idle, 1);
    do_cfg(2'b10, 4'd8, 2'b01, 8'd0);
    frm_finish(1'b1, s, q, idx);
    chk(!s, "R7", "dropped frame end closes nothing", s, 0);
    chk(rd_idx == m_rd, "R7", "rd_idx kept", rd_idx, m_rd);
  endtask

  task automatic t_timeout();
    bit s, q; int idx; int seen; bit irq_seen;
    do_cfg(2'b10, 4'd8, 2'b01, 8'd3);
    run_frame(1'b0, s, q, idx);
    chk(!s, "R8", "partial buffer stays open", s, 0);
    seen = -1; irq_seen = 0;
    for (int k = 1; k <= 40 && seen < 0; k++) begin
      @(negedge clk);
      if (stat_wr) begin seen = k; irq_seen = irq; idx = int'(stat_idx); end
    end
    m_rd = (m_rd + 1) % m_size;
    chk(seen == 3 * TICK, "R8", "timeout close cycle", seen, 3 * TICK);
    chk(idx == m_rd, "R8", "timeout stat_idx", idx, m_rd);
    chk(irq_seen, "R9", "irq on timeout close", irq_seen, 1);
    do_cfg(2'b10, 4'd8, 2'b01, 8'd0);
    run_frame(1'b0, s, q, idx);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (stat_wr) seen++;
    end
    chk(seen == 0, "R8", "zero timeout never closes", seen, 0);
    run_frame(1'b1, s, q, idx);
    m_rd = (m_rd + 1) % m_size;
    chk(s && idx == m_rd, "R8", "partial closed by filled frame", idx, m_rd);
  endtask

  task automatic t_irq_dest();
    bit s, q; int idx;
    do_cfg(2'b10, 4'd8, 2'b00, 8'd0);
    run_frame(1'b1, s, q, idx);
    m_rd = (m_rd + 1) % m_size;
    chk(s && !q, "R9", "no irq with dest 00", q, 0);
    do_cfg(2'b10, 4'd8, 2'b10, 8'd0);
    run_frame(1'b1, s, q, idx);
    m_rd = (m_rd + 1) % m_size;
    chk(s && !q, "R9", "no irq with dest 10", q, 0);
    chk(rd_idx == m_rd, "R5", "rd_idx after closes", rd_idx, m_rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_basic();
    t_wrap();
    t_eof();
    t_stop();
    t_timeout();
    t_irq_dest();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule